// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Zero and Carry Flags

This block is the arithmetic and logic stage of a small accumulator machine. It takes two operands, the accumulator `a_in` and the second register `b_in`, together with an operation code. It computes one of nine operations: add, add with carry, subtract, increment, decrement, compare, AND, OR and XOR. The result register and the zero and carry flags are loaded only on the execute strobe.

A second strobe, the store phase, drives the held result onto a shared bus and asks for a write into the accumulator. Compare takes only the execute phase. It updates the flags, leaves the result register as it was, and never requests a write, so the accumulator keeps its value. A condition evaluator reads the stored flags and answers the branch tests. Equal and not-equal use the same encodings as zero set and zero clear.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the result register, the zero flag, the carry flag and the compare marker are cleared. After reset, `bus_out` is 0 with `out_en` high, and `a_we` is 1 with `store_en` high.
- R2: Opcodes 0 (add), 1 (add with carry) and 3 (increment) load the result register with the sum modulo 2^WIDTH. The carry flag takes bit WIDTH of the full sum. Increment adds 1 to `a_in`.
- R3: Opcodes 2 (subtract) and 4 (decrement) load `a_in - b_in` and `a_in - 1` modulo 2^WIDTH. The carry flag is set exactly when a borrow occurs: the unsigned minuend is less than the subtrahend.
- R4: Add with carry adds the carry flag stored before that execute edge as a carry-in.
- R5: Opcodes 6 (AND), 7 (OR) and 8 (XOR) load the bitwise result and clear the carry flag.
- R6: On every valid execute, the zero flag is set exactly when the operation's WIDTH-bit result is 0.
- R7: Opcode 5 (compare) sets zero and carry as subtract would, but leaves the result register unchanged. Until the next valid execute, `a_we` stays 0 while `store_en` is high.
- R8: With `exec_en` low, the result register and both flags hold, whatever the operands and opcode.
- R9: `bus_out` equals the result register while `out_en` is high and is 0 while it is low. `a_we` is high only while `store_en` is high.
- R10: `cond_true` reads the stored flags by `cond_sel` as follows:
  - 0: always true
  - 1: zero set (equal)
  - 2: zero clear (not equal)
  - 3: carry set
  - 4: carry clear
  - 5 to 7: false
- R11: An execute with an opcode from 9 to 15 changes neither the result register nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| a_in | input | WIDTH | Accumulator operand |
| b_in | input | WIDTH | Second operand |
| exec_en | input | 1 | Execute strobe: load result and flags |
| store_en | input | 1 | Store phase: request accumulator write |
| out_en | input | 1 | Drive the result onto the bus |
| cond_sel | input | 3 | Branch condition selector |
| bus_out | output | WIDTH | Result onto the shared bus, 0 when not enabled |
| a_we | output | 1 | Accumulator write request |
| zero_flag | output | 1 | Stored zero flag |
| carry_flag | output | 1 | Stored carry/borrow flag |
| cond_true | output | 1 | Selected branch condition holds |

## Verification
The bench builds the unit with WIDTH set to 4. At that width every operand pair of every opcode can be applied, each with the carry flag preloaded both clear and set. The sweep therefore reaches every wrap-around, every borrow and every zero result, including 15+15+1 and 0-1. Dedicated passes cover these points:
- holding with the strobe low;
- compare followed by a store;
- the seven undefined opcodes;
- all eight condition selections against both flag values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W   = 4;
  localparam int COND_W = 3;

  localparam logic [OP_W-1:0] OP_ADD = 4'd0;
  localparam logic [OP_W-1:0] OP_ADC = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB = 4'd2;
  localparam logic [OP_W-1:0] OP_INC = 4'd3;
  localparam logic [OP_W-1:0] OP_DEC = 4'd4;
  localparam logic [OP_W-1:0] OP_CMP = 4'd5;
  localparam logic [OP_W-1:0] OP_AND = 4'd6;
  localparam logic [OP_W-1:0] OP_OR  = 4'd7;
  localparam logic [OP_W-1:0] OP_XOR = 4'd8;

  localparam logic [COND_W-1:0] CC_ALWAYS = 3'd0;
  localparam logic [COND_W-1:0] CC_ZSET   = 3'd1;
  localparam logic [COND_W-1:0] CC_ZCLR   = 3'd2;
  localparam logic [COND_W-1:0] CC_CSET   = 3'd3;
  localparam logic [COND_W-1:0] CC_CCLR   = 3'd4;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             cflag,
  output logic             is_arith
);

  localparam int EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] opnd2;
  logic             cin;
  logic             borrow_mode;
  logic [EXT_W-1:0] ext;

  // One adder serves every arithmetic opcode; subtraction is a + ~b + 1
  // and the carry-out is inverted to become a borrow.
  always_comb begin
    opnd2       = '0;
    cin         = 1'b0;
    borrow_mode = 1'b0;
    is_arith    = 1'b1;
    case (op)
      OP_ADD: begin opnd2 = b;           cin = 1'b0;     end
      OP_ADC: begin opnd2 = b;           cin = carry_in; end
      OP_SUB,
      OP_CMP: begin opnd2 = ~b;          cin = 1'b1; borrow_mode = 1'b1; end
      OP_INC: begin opnd2 = '0;          cin = 1'b1;     end
      OP_DEC: begin opnd2 = {WIDTH{1'b1}}; cin = 1'b0; borrow_mode = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  assign ext   = {1'b0, a} + {1'b0, opnd2} + {{WIDTH{1'b0}}, cin};
  assign sum   = ext[WIDTH-1:0];
  assign cflag = ext[WIDTH] ^ borrow_mode;

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             is_logic
);

  always_comb begin
    res      = '0;
    is_logic = 1'b1;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: is_logic = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_en,
  input  logic              valid,
  input  logic              write_res,
  input  logic [WIDTH-1:0]  new_res,
  input  logic              new_carry,
  input  logic [COND_W-1:0] cond_sel,
  output logic [WIDTH-1:0]  result_q,
  output logic              zero_q,
  output logic              carry_q,
  output logic              cond_true
);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      zero_q   <= 1'b0;
      carry_q  <= 1'b0;
    end else if (exec_en && valid) begin
      zero_q  <= (new_res == '0);
      carry_q <= new_carry;
      if (write_res) result_q <= new_res;
    end
  end

  always_comb begin
    case (cond_sel)
      CC_ALWAYS: cond_true = 1'b1;
      CC_ZSET:   cond_true = zero_q;
      CC_ZCLR:   cond_true = !zero_q;
      CC_CSET:   cond_true = carry_q;
      CC_CCLR:   cond_true = !carry_q;
      default:   cond_true = 1'b0;
    endcase
  end

  // R8: flags and result hold without the execute strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> ($stable(zero_q) && $stable(carry_q) && $stable(result_q)));

  // R6: a written result and the zero flag agree
  p_zero_match_r6: assert property (@(posedge clk) disable iff (rst)
    (exec_en && valid && write_res) |=> (zero_q == (result_q == '0)));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [WIDTH-1:0]  a_in,
  input  logic [WIDTH-1:0]  b_in,
  input  logic              exec_en,
  input  logic              store_en,
  input  logic              out_en,
  input  logic [COND_W-1:0] cond_sel,
  output logic [WIDTH-1:0]  bus_out,
  output logic              a_we,
  output logic              zero_flag,
  output logic              carry_flag,
  output logic              cond_true
);

  logic [WIDTH-1:0] arith_res, logic_res, new_res, result_q;
  logic             arith_c, is_arith, is_logic, valid, write_res, new_carry;
  logic             cmp_q;

  alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op_sel), .a(a_in), .b(b_in), .carry_in(carry_flag),
    .sum(arith_res), .cflag(arith_c), .is_arith(is_arith)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op_sel), .a(a_in), .b(b_in), .res(logic_res), .is_logic(is_logic)
  );

  assign valid     = is_arith | is_logic;
  assign write_res = (op_sel != OP_CMP);
  assign new_res   = is_arith ? arith_res : logic_res;
  assign new_carry = is_arith & arith_c;

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst(rst), .exec_en(exec_en), .valid(valid),
    .write_res(write_res), .new_res(new_res), .new_carry(new_carry),
    .cond_sel(cond_sel), .result_q(result_q), .zero_q(zero_flag),
    .carry_q(carry_flag), .cond_true(cond_true)
  );

  // Marks that the last executed operation was a compare
  always_ff @(posedge clk) begin
    if (rst)                   cmp_q <= 1'b0;
    else if (exec_en && valid) cmp_q <= !write_res;
  end

  assign a_we    = store_en & !cmp_q;
  assign bus_out = out_en ? result_q : '0;

  // R7: compare leaves the result register untouched
  p_cmp_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel == OP_CMP) |=> $stable(bus_out) || !out_en || $changed(out_en));

  // R5: logic operations clear carry
  p_logic_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (exec_en && is_logic) |=> !carry_flag);

  // R11: undefined opcodes leave the flags alone
  p_bad_op_r11: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !valid) |=> ($stable(zero_flag) && $stable(carry_flag)));

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

  localparam int CLK_PERIOD = 10;
  localparam int BW  = 4;
  localparam int MOD = 1 << BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op_sel = '0;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic          exec_en = 1'b0, store_en = 1'b0, out_en = 1'b0;
  logic [2:0]    cond_sel = '0;
  logic [BW-1:0] bus_out;
  logic          a_we, zero_flag, carry_flag, cond_true;

  int vectors = 0;
  int fails   = 0;

  int m_res = 0, m_z = 0, m_c = 0, m_cmp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu #(.WIDTH(BW)) u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .a_in(a_in), .b_in(b_in),
    .exec_en(exec_en), .store_en(store_en), .out_en(out_en),
    .cond_sel(cond_sel), .bus_out(bus_out), .a_we(a_we),
    .zero_flag(zero_flag), .carry_flag(carry_flag), .cond_true(cond_true)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bench model of one execute, derived from the requirements
  task automatic model(input int op, input int a, input int b);
    int s;
    int r;
    int c;
    int ok;
    ok = 1;
    r  = 0;
    c  = 0;
    case (op)
      0: begin s = a + b;       r = s % MOD; c = int'(s >= MOD); end
      1: begin s = a + b + m_c; r = s % MOD; c = int'(s >= MOD); end
      2, 5: begin r = (a - b + MOD) % MOD; c = int'(a < b); end
      3: begin s = a + 1;       r = s % MOD; c = int'(s >= MOD); end
      4: begin r = (a + MOD - 1) % MOD; c = int'(a == 0); end
      6: r = a & b;
      7: r = a | b;
      8: r = a ^ b;
      default: ok = 0;
    endcase
    if (ok == 1) begin
      m_z   = int'(r == 0);
      m_c   = c;
      m_cmp = int'(op == 5);
      if (op != 5) m_res = r;
    end
  endtask

  task automatic exec_op(input int op, input int a, input int b);
    @(negedge clk);
    op_sel  = 4'(op);
    a_in    = BW'(a);
    b_in    = BW'(b);
    exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
    model(op, a, b);
  endtask

  task automatic check_state(input string tag);
    out_en   = 1'b1;
    store_en = 1'b1;
    #1;
    check({tag, " bus"},   int'(bus_out),    m_res);
    check({tag, " zero"},  int'(zero_flag),  m_z);
    check({tag, " carry"}, int'(carry_flag), m_c);
    check({tag, " a_we"},  int'(a_we),       1 - m_cmp);
    out_en   = 1'b0;
    store_en = 1'b0;
    #1;
    check("R9 bus idle", int'(bus_out), 0);
    check("R9 a_we idle", int'(a_we), 0);
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0, 3: return "R2";
      1: return "R4";
      2, 4: return "R3";
      5: return "R7";
      6, 7, 8: return "R5";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_state("R1 reset");

    // R2..R6 sweep with the carry flag preloaded clear and set
    for (int op = 0; op < 9; op++)
      for (int cin = 0; cin < 2; cin++)
        for (int a = 0; a < MOD; a++)
          for (int b = 0; b < MOD; b++) begin
            if (cin == 1) exec_op(2, 0, 1);
            else          exec_op(0, 0, 0);
            exec_op(op, a, b);
            check_state(op_tag(op));
          end

    // R7: compare after a stored result keeps it and blocks the write
    exec_op(0, 5, 6);
    exec_op(5, 7, 7);
    check_state("R7 cmp equal");
    exec_op(5, 2, 9);
    check_state("R7 cmp borrow");

    // R8: no execute strobe, operands and opcode churn
    exec_op(8, 9, 3);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      op_sel = 4'(k);
      a_in   = BW'(15 - k);
      b_in   = BW'(k);
    end
    @(negedge clk);
    check_state("R8 hold");

    // R11: undefined opcodes
    exec_op(2, 0, 3);
    for (int op = 9; op < 16; op++) begin
      exec_op(op, 0, 0);
      check_state("R11 bad op");
    end

    // R10: every condition selection against both flag values
    for (int f = 0; f < 4; f++) begin
      case (f)
        0: exec_op(6, 0, 0);
        1: exec_op(7, 1, 0);
        2: exec_op(0, 15, 1);
        default: exec_op(2, 1, 2);
      endcase
      for (int s = 0; s < 8; s++) begin
        int e;
        cond_sel = 3'(s);
        #1;
        case (s)
          0: e = 1;
          1: e = m_z;
          2: e = 1 - m_z;
          3: e = m_c;
          4: e = 1 - m_c;
          default: e = 0;
        endcase
        check("R10 cond", int'(cond_true), e);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule